// File: doc/BRIEF.md
# Paced FIFO-Fed DAC Stream Controller

This block buffers 16-bit output words written by a host and streams them to one or two digital-to-analog channels. The speed is set by a pacer tick input. The host fills a word FIFO and watches a half-full flag to know when to top it up. A one-cycle clear pulse empties the FIFO before a new run.

A start level either begins streaming at once or arms the block to wait for an external trigger pulse. While streaming, each pacer tick takes one word from the FIFO. The word appears at the output with a one-cycle load strobe and a channel select. When two channels are enabled, successive words alternate between them.

The block also gives each word as a signed value relative to zero volts. That value depends on whether the data uses offset-binary (bipolar) or straight-binary (unipolar) coding. A sticky underrun flag records any cycle in which the FIFO was empty while streaming.

Top module: `dac_stream_ctrl`

## Requirements
- R1: After a synchronous reset, the FIFO is empty, `run_state` is idle (0), `dac_load`, `dac_chan`, `underrun` and `half_full` are 0, and `dac_word` and `dac_value` are 0.
- R2: With `ext_trig_sel` low, `start` high moves `run_state` from idle (0) to running (2) at the next edge. `start` low returns the block to idle at the next edge from any state, and does not empty the FIFO.
- R3: With `ext_trig_sel` high, `start` moves idle to armed (1). Armed moves to running only at an edge where `ext_trig` is high. No word is taken while idle or armed.
- R4: Streaming means running with `aout_en` high. At each edge where the block is streaming, `pacer_tick` is high and the FIFO is not empty, the oldest word is removed. That word is on `dac_word`, with `dac_load` high, for exactly the following cycle.
- R5: With `dual_chan` high, loads alternate channel 0, 1, 0, … and the first load after leaving idle goes to channel 0. With `dual_chan` low, `dac_chan` takes `chan_sel` at the load.
- R6: With `aout_en` low, pacer ticks take no word and produce no load.
- R7: A tick while streaming with an empty FIFO produces no load, and `dac_word`/`dac_value` keep their last values.
- R8: A `fifo_clr` pulse empties the FIFO at the next edge, whatever `wr_data` holds. It takes priority over a write in the same cycle.
- R9: A write while the FIFO holds DEPTH words is dropped, even if a word is removed in the same cycle.
- R10: `half_full` is high exactly when the FIFO holds at least DEPTH/2 words.
- R11: `underrun` is set at the edge after any cycle where the block is streaming with an empty FIFO. It stays set until `underrun_clr`, and setting wins over a clear in the same cycle.
- R12: `dac_value` is the loaded word minus 32767 when `unipolar` is low (0000h gives -32767, 7FFFh gives 0, FFFFh gives +32768). When `unipolar` is high it is the word itself, 0 to 65535. The `unipolar` value is taken at the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write of one word into the FIFO |
| wr_data | input | 16 | Word to write |
| fifo_clr | input | 1 | Write to the clear address; empties the FIFO |
| aout_en | input | 1 | Global analog-output enable |
| start | input | 1 | Run/arm request level |
| ext_trig_sel | input | 1 | 1 = start arms and waits for the trigger |
| ext_trig | input | 1 | External trigger pulse |
| dual_chan | input | 1 | 1 = alternate words between both channels |
| chan_sel | input | 1 | Channel used when `dual_chan` is low |
| unipolar | input | 1 | 1 = straight-binary data, 0 = offset-binary |
| pacer_tick | input | 1 | One-cycle pacer pulse |
| underrun_clr | input | 1 | Clears the sticky underrun flag |
| dac_load | output | 1 | One-cycle load strobe for the DAC |
| dac_chan | output | 1 | Channel receiving the current word |
| dac_word | output | 16 | Raw word presented to the DAC |
| dac_value | output | 17 | Signed value of the word relative to zero volts |
| half_full | output | 1 | FIFO holds at least half its depth |
| underrun | output | 1 | Sticky FIFO-empty-while-streaming flag |
| run_state | output | 2 | 0 idle, 1 armed, 2 running |

## Verification
A wrong FIFO pointer or count shows up at the next load as an out-of-order or repeated `dac_word`. It also shows up in the same cycle as a `half_full` edge at the wrong fill level. A wrong run state, or a channel toggle that is not reset, becomes visible on `run_state` at the next edge and on `dac_chan` at the next load. A reference model compares every output on every clock, through a directed run and a long run of mixed random stimulus. A single bad cycle is therefore reported one clock after it occurs.

// File: rtl/dac_stream_pkg.sv
package dac_stream_pkg;

    localparam int DATA_W = 16;
    localparam int MID_CODE = (1 << (DATA_W - 1)) - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } run_state_e;

    typedef struct packed {
        logic              load;
        logic              chan;
        logic [DATA_W-1:0] word;
        logic signed [DATA_W:0] value;
    } dac_out_s;

    // Signed value of a word relative to zero volts under the chosen coding.
    function automatic logic signed [DATA_W:0] code_to_value(
        input logic [DATA_W-1:0] w,
        input logic              uni
    );
        logic signed [DATA_W:0] ext;
        ext = $signed({1'b0, w});
        if (uni) return ext;
        return ext - (DATA_W + 1)'(MID_CODE);
    endfunction

endpackage

// File: rtl/dac_stream_fifo.sv
module dac_stream_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         half
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign do_push = push && (count != FULL_CNT) && !clr;
    assign do_pop  = pop && (count != '0) && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    assign head  = mem[rptr];
    assign empty = (count == '0);
    assign half  = (count >= HALF_CNT);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT); // R9
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0)); // R8

endmodule

// File: rtl/dac_stream_seq.sv
module dac_stream_seq
    import dac_stream_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ext_trig_sel,
    input  logic              ext_trig,
    input  logic              aout_en,
    input  logic              pacer_tick,
    input  logic              dual_chan,
    input  logic              chan_sel,
    input  logic              unipolar,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] head,
    output logic              pop,
    output logic              streaming,
    output run_state_e        state,
    output dac_out_s          dout
);
    run_state_e nxt;
    logic       toggle;

    assign streaming = (state == ST_RUN) && aout_en;
    assign pop       = streaming && pacer_tick && !fifo_empty;

    always_comb begin
        nxt = state;
        if (!start) begin
            nxt = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  nxt = ext_trig_sel ? ST_ARMED : ST_RUN;
                ST_ARMED: nxt = ext_trig ? ST_RUN : ST_ARMED;
                default:  nxt = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            toggle <= 1'b0;
            dout   <= '0;
        end else begin
            state     <= nxt;
            dout.load <= pop;
            if (pop) begin
                dout.word  <= head;
                dout.value <= code_to_value(head, unipolar);
                dout.chan  <= dual_chan ? toggle : chan_sel;
            end
            if (state == ST_IDLE)
                toggle <= 1'b0;
            else if (pop && dual_chan)
                toggle <= ~toggle;
        end
    end

    AST_LOAD_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        dout.load |-> $past(pacer_tick)); // R4
    AST_LOAD_ONLY_STREAMING: assert property (@(posedge clk) disable iff (rst)
        dout.load |-> $past(state == ST_RUN && aout_en)); // R6
    AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && start && !ext_trig) |=> (state == ST_ARMED)); // R3

endmodule

// File: rtl/dac_stream_flags.sv
module dac_stream_flags (
    input  logic clk,
    input  logic rst,
    input  logic streaming,
    input  logic fifo_empty,
    input  logic clr,
    output logic underrun
);
    logic set_now;
    assign set_now = streaming && fifo_empty;

    always_ff @(posedge clk) begin
        if (rst)          underrun <= 1'b0;
        else if (set_now) underrun <= 1'b1;
        else if (clr)     underrun <= 1'b0;
    end

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (underrun && !clr) |=> underrun); // R11
    AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (rst)
        (streaming && fifo_empty) |=> underrun); // R11

endmodule

// File: rtl/dac_stream_ctrl.sv
module dac_stream_ctrl
    import dac_stream_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     fifo_clr,
    input  logic                     aout_en,
    input  logic                     start,
    input  logic                     ext_trig_sel,
    input  logic                     ext_trig,
    input  logic                     dual_chan,
    input  logic                     chan_sel,
    input  logic                     unipolar,
    input  logic                     pacer_tick,
    input  logic                     underrun_clr,
    output logic                     dac_load,
    output logic                     dac_chan,
    output logic [DATA_W-1:0]        dac_word,
    output logic signed [DATA_W:0]   dac_value,
    output logic                     half_full,
    output logic                     underrun,
    output logic [1:0]               run_state
);
    logic              pop, streaming, fifo_empty;
    logic [DATA_W-1:0] head;
    run_state_e        state;
    dac_out_s          dout;

    dac_stream_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
        .clk(clk), .rst(rst), .clr(fifo_clr), .push(wr_en), .din(wr_data),
        .pop(pop), .head(head), .empty(fifo_empty), .half(half_full)
    );

    dac_stream_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .ext_trig_sel(ext_trig_sel),
        .ext_trig(ext_trig), .aout_en(aout_en), .pacer_tick(pacer_tick),
        .dual_chan(dual_chan), .chan_sel(chan_sel), .unipolar(unipolar),
        .fifo_empty(fifo_empty), .head(head), .pop(pop),
        .streaming(streaming), .state(state), .dout(dout)
    );

    dac_stream_flags u_flags (
        .clk(clk), .rst(rst), .streaming(streaming), .fifo_empty(fifo_empty),
        .clr(underrun_clr), .underrun(underrun)
    );

    assign dac_load  = dout.load;
    assign dac_chan  = dout.chan;
    assign dac_word  = dout.word;
    assign dac_value = dout.value;
    assign run_state = state;

endmodule

// File: tb/dac_stream_ctrl_tb.sv
module dac_stream_ctrl_tb;
    localparam int DEPTH = 16;

    logic clk = 0, rst = 1;
    logic wr_en = 0, fifo_clr = 0, aout_en = 0, start = 0, ext_trig_sel = 0;
    logic ext_trig = 0, dual_chan = 0, chan_sel = 0, unipolar = 0;
    logic pacer_tick = 0, underrun_clr = 0;
    logic [15:0] wr_data = 0;
    logic dac_load, dac_chan, half_full, underrun;
    logic [15:0] dac_word;
    logic signed [16:0] dac_value;
    logic [1:0] run_state;

    int checks = 0, failures = 0;
    bit chk_en = 0, done = 0;

    always #2 clk = ~clk; // 250 MHz

    dac_stream_ctrl #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_clr(fifo_clr), .aout_en(aout_en), .start(start),
        .ext_trig_sel(ext_trig_sel), .ext_trig(ext_trig),
        .dual_chan(dual_chan), .chan_sel(chan_sel), .unipolar(unipolar),
        .pacer_tick(pacer_tick), .underrun_clr(underrun_clr),
        .dac_load(dac_load), .dac_chan(dac_chan), .dac_word(dac_word),
        .dac_value(dac_value), .half_full(half_full), .underrun(underrun),
        .run_state(run_state)
    );

    // Behavioural reference model
    logic [15:0] q[$];
    int  m_state = 0;
    bit  m_load = 0, m_chan = 0, m_under = 0, m_tog = 0;
    logic [15:0] m_word = 0;
    int  m_value = 0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_state = 0; m_load = 0; m_chan = 0; m_under = 0;
            m_tog = 0; m_word = 0; m_value = 0;
        end else begin
            bit strm, popn, setu;
            int nst;
            strm = (m_state == 2) && aout_en;
            popn = strm && pacer_tick && (q.size() > 0);
            setu = strm && (q.size() == 0);
            if (!start) nst = 0;
            else if (m_state == 0) nst = ext_trig_sel ? 1 : 2;
            else if (m_state == 1) nst = ext_trig ? 2 : 1;
            else nst = 2;
            m_load = popn;
            if (popn) begin
                m_word  = q[0];
                m_value = unipolar ? int'(q[0]) : int'(q[0]) - 32767;
                m_chan  = dual_chan ? m_tog : chan_sel;
            end
            if (m_state == 0) m_tog = 0;
            else if (popn && dual_chan) m_tog = ~m_tog;
            if (fifo_clr) q.delete();
            else begin
                int sz;
                sz = q.size();
                if (popn) void'(q.pop_front());
                if (wr_en && sz < DEPTH) q.push_back(wr_data);
            end
            if (setu) m_under = 1;
            else if (underrun_clr) m_under = 0;
            m_state = nst;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !rst) begin
            chk(dac_load == m_load, "R4 R6 R7 dac_load", dac_load, m_load);
            chk(dac_word == m_word, "R4 R7 dac_word", dac_word, m_word);
            chk(int'(dac_value) == m_value, "R12 dac_value", int'(dac_value), m_value);
            chk(dac_chan == m_chan, "R5 dac_chan", dac_chan, m_chan);
            chk(int'(run_state) == m_state, "R2 R3 run_state", run_state, m_state);
            chk(half_full == (q.size() >= DEPTH / 2), "R8 R9 R10 half_full",
                half_full, q.size() >= DEPTH / 2);
            chk(underrun == m_under, "R11 underrun", underrun, m_under);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] d);
        wr_en = 1; wr_data = d; step(); wr_en = 0;
    endtask

    task automatic tick(input int gap);
        pacer_tick = 1; step(); pacer_tick = 0; step(gap);
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        rst = 0;
        step();
        // R1 reset state
        chk(run_state == 0 && !dac_load && !underrun && !half_full && dac_word == 0
            && dac_value == 0 && !dac_chan, "R1 reset state", run_state, 0);
        chk_en = 1;

        // R2 immediate start, single channel, bipolar codes incl. extremes (R12)
        aout_en = 1;
        write_word(16'h0000); write_word(16'h7FFF); write_word(16'hFFFF);
        write_word(16'h1234); write_word(16'h8000);
        start = 1; step(2);
        repeat (7) tick(2);          // R7: last ticks find FIFO empty, R11 underrun
        start = 0; step(2);
        underrun_clr = 1; step(); underrun_clr = 0; step();

        // R9 overflow, R10 half-full, R8 clear before run
        fifo_clr = 1; wr_en = 1; wr_data = 16'hDEAD; step(); fifo_clr = 0; wr_en = 0;
        for (int i = 0; i < DEPTH + 3; i++) write_word(16'(i * 257 + 3));
        // R3 armed waits, R5 dual channel alternation
        dual_chan = 1; ext_trig_sel = 1; start = 1; step(2);
        repeat (3) tick(1);
        ext_trig = 1; step(); ext_trig = 0;
        repeat (5) tick(0);
        // R6 disabled output ignores ticks
        aout_en = 0; repeat (4) tick(1); aout_en = 1;
        unipolar = 1; repeat (4) tick(1);
        // R2 stop keeps the FIFO, restart resets channel order
        start = 0; step(2); ext_trig_sel = 0; start = 1; step(2);
        repeat (DEPTH) tick(1);
        start = 0; step(2);

        // mixed random stimulus
        void'($urandom(32'h5eed));
        for (int c = 0; c < 20000; c++) begin
            wr_en        = ($urandom_range(0, 99) < 40);
            wr_data      = 16'($urandom());
            fifo_clr     = ($urandom_range(0, 99) < 2);
            pacer_tick   = ($urandom_range(0, 99) < 30);
            ext_trig     = ($urandom_range(0, 99) < 8);
            underrun_clr = ($urandom_range(0, 99) < 5);
            if ($urandom_range(0, 99) < 3) start = ~start;
            if ($urandom_range(0, 99) < 3) ext_trig_sel = ~ext_trig_sel;
            if ($urandom_range(0, 99) < 2) aout_en = ~aout_en;
            if ($urandom_range(0, 99) < 3) dual_chan = ~dual_chan;
            if ($urandom_range(0, 99) < 3) chan_sel = ~chan_sel;
            if ($urandom_range(0, 99) < 3) unipolar = ~unipolar;
            step();
        end
        wr_en = 0; fifo_clr = 0; pacer_tick = 0; ext_trig = 0; underrun_clr = 0;
        step(3);
        finish_run();
    end
endmodule